// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder

This block adds K unsigned operands of W bits each and returns their exact total. The operands enter together as one packed array. A tree of three-to-two compressor rows shrinks them to two words. Each row is a set of independent full adders with no carry chain between them. The carry word of each row is moved up one bit position by wiring alone.

Rows are added level by level until two words are left. One carry-propagate adder then merges those two words. The result is captured in an output register, so every input vector has exactly one cycle of latency. The result has W + ceil(log2 K) bits, which is enough for any combination of operands.

The block serves as the accumulation stage of multipliers and filters, where many partial values must be combined in one step.

Top module: `csa_sum_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, `sum_o` holds zero after that edge, whatever values are on `opnd_i`.
- R2: When `rst` is low, `sum_o` after each rising edge equals the unsigned sum of all K operands sampled at that edge. Operand j is `opnd_i[j]`, which occupies bits [j*W +: W] of the packed input.
- R3: The output has W + ceil(log2 K) bits and never overflows. With every operand at all ones, the result is exactly K*(2^W-1), which is 90 for the defaults.
- R4: When every operand is zero, the result is zero.
- R5: A three-operand build is a single compressor row followed by the final adder. For the operands 9, 12 and 13 it returns 34. That row's sum word is 8 and its carry word is 13, and 8 + 2*13 = 34.
- R6: With the default build, the operands 13, 10, 5, 11, 12 and 1 give 52.
- R7: The result does not depend on the slot each operand occupies. Any permutation of one operand set gives the same total.
- R8: A single nonzero operand in any one slot, with all other slots zero, is returned unchanged. This holds for slots that bypass a compressor row at some level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the result |
| opnd_i | input | K*W (packed K x W) | The K unsigned operands; slot j is `opnd_i[j]` |
| sum_o | output | W+ceil(log2 K) | Registered total of all operands |

## Verification
The hardest paths to reach from the ports are the operand slots that skip a compressor row at some level. Only the values in those slots travel through such a path. Walking one full-scale operand across every slot, with the others at zero, forces each bypass path to carry the whole result alone. Permuted copies of one operand set then check that bypassed and compressed slots combine in the same way. All-ones operands drive the final adder's carry ripple across its full width.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Number of words left after lvl rounds of three-to-two reduction.
  function automatic int words_after(input int k, input int lvl);
    int n;
    n = k;
    for (int i = 0; i < lvl; i++) n = 2 * (n / 3) + (n % 3);
    return n;
  endfunction

  // Rounds needed to bring k words down to two.
  function automatic int level_count(input int k);
    int n;
    int l;
    n = k;
    l = 0;
    for (int i = 0; i < 64; i++) begin
      if (n > 2) begin
        n = 2 * (n / 3) + (n % 3);
        l++;
      end
    end
    return l;
  endfunction

endpackage

// File: rtl/csa_row.sv
// One three-to-two compressor row: independent full adders, no carry chain.
// The carry word leaves already doubled (shifted up one bit by wiring).
module csa_row #(
  parameter int OW = 7
) (
  input  logic [OW-1:0] a_i,
  input  logic [OW-1:0] b_i,
  input  logic [OW-1:0] c_i,
  output logic [OW-1:0] sum_o,
  output logic [OW-1:0] carry_o
);
  assign carry_o[0] = 1'b0;

  for (genvar i = 0; i < OW; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    // The top carry would land beyond the result width; since every partial
    // total is bounded by the final one, it is always zero and is not built.
    if (i < OW - 1) begin : g_cy
      assign carry_o[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
    end
  end
endmodule

// File: rtl/csa_tree.sv
// Reduces K operands to two words through levels of compressor rows.
module csa_tree
  import csa_pkg::*;
#(
  parameter int K  = 6,
  parameter int W  = 4,
  parameter int OW = 7
) (
  input  logic [K-1:0][W-1:0] ops_i,
  output logic [OW-1:0]       word_a_o,
  output logic [OW-1:0]       word_b_o
);
  localparam int LEVELS = level_count(K);

  for (genvar l = 0; l <= LEVELS; l++) begin : stg
    localparam int N = words_after(K, l);
    logic [OW-1:0] w [N];

    if (l == 0) begin : g_load
      for (genvar j = 0; j < K; j++) begin : g_ext
        assign w[j] = {{(OW-W){1'b0}}, ops_i[j]};
      end
    end else begin : g_reduce
      localparam int NP   = words_after(K, l - 1);
      localparam int GRPS = NP / 3;
      localparam int LEFT = NP % 3;
      for (genvar g = 0; g < GRPS; g++) begin : g_row
        csa_row #(.OW(OW)) u_row (
          .a_i    (stg[l-1].w[3*g]),
          .b_i    (stg[l-1].w[3*g+1]),
          .c_i    (stg[l-1].w[3*g+2]),
          .sum_o  (w[2*g]),
          .carry_o(w[2*g+1])
        );
      end
      for (genvar j = 0; j < LEFT; j++) begin : g_pass
        assign w[2*GRPS+j] = stg[l-1].w[3*GRPS+j];
      end
    end
  end

  assign word_a_o = stg[LEVELS].w[0];
  assign word_b_o = stg[LEVELS].w[1];
endmodule

// File: rtl/cpa_ripple.sv
// Final carry-propagate adder merging the two remaining words.
module cpa_ripple #(
  parameter int OW = 7
) (
  input  logic [OW-1:0] x_i,
  input  logic [OW-1:0] y_i,
  output logic [OW-1:0] s_o
);
  logic [OW-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < OW; i++) begin : g_bit
    assign s_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
    if (i < OW - 1) begin : g_cy
      assign cy[i+1] = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
    end
  end
endmodule

// File: rtl/csa_sum_top.sv
module csa_sum_top #(
  parameter  int K  = 6,
  parameter  int W  = 4,
  localparam int OW = W + $clog2(K)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [K-1:0][W-1:0] opnd_i,
  output logic [OW-1:0]      sum_o
);
  localparam int RW = OW + 8;

  logic [OW-1:0] word_a;
  logic [OW-1:0] word_b;
  logic [OW-1:0] total;

  csa_tree #(.K(K), .W(W), .OW(OW)) u_tree (
    .ops_i   (opnd_i),
    .word_a_o(word_a),
    .word_b_o(word_b)
  );

  cpa_ripple #(.OW(OW)) u_cpa (
    .x_i(word_a),
    .y_i(word_b),
    .s_o(total)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_o <= '0;
    else     sum_o <= total;
  end

  // Plain arithmetic total, used only by the checks below.
  logic [RW-1:0] chk_sum;
  always_comb begin
    chk_sum = '0;
    for (int j = 0; j < K; j++) chk_sum = chk_sum + RW'(opnd_i[j]);
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sum_o == '0);

  assert_registered_total_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> RW'(sum_o) == $past(chk_sum));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    chk_sum[RW-1:OW] == '0);

  // Tree conservation: the two words reaching the final adder keep the total.
  assert_tree_conserves_R7: assert property (@(posedge clk) disable iff (rst)
    RW'(word_a) + RW'(word_b) == chk_sum);

  assert_zero_in_zero_out_R4: assert property (@(posedge clk) disable iff (rst)
    (opnd_i == '0) |=> sum_o == '0);
endmodule

// File: tb/sim_csa_sum_top.sv
module sim_csa_sum_top;
  localparam int CLK_PERIOD = 10;
  localparam int K   = 6;
  localparam int W   = 4;
  localparam int OW  = W + $clog2(K);
  localparam int OW3 = W + $clog2(3);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [K-1:0][W-1:0] opnd  = '0;
  logic [2:0][W-1:0]   opnd3 = '0;
  logic [OW-1:0]  sum;
  logic [OW3-1:0] sum3;

  int applied = 0;
  int bad     = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_sum_top #(.K(K), .W(W)) u0 (.clk(clk), .rst(rst), .opnd_i(opnd), .sum_o(sum));
  csa_sum_top #(.K(3), .W(W)) u1 (.clk(clk), .rst(rst), .opnd_i(opnd3), .sum_o(sum3));

  function automatic int ref_total(input logic [K-1:0][W-1:0] v);
    int s = 0;
    for (int j = 0; j < K; j++) s += int'(v[j]);
    return s;
  endfunction

  task automatic check(input int act, input int exp, input string req);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture it, sample at the next falling edge.
  task automatic apply(input logic [K-1:0][W-1:0] v, input string req);
    opnd = v;
    @(negedge clk);
    check(int'(sum), ref_total(v), req);
  endtask

  function automatic logic [K-1:0][W-1:0] pack6(input int a, b, c, d, e, f);
    logic [K-1:0][W-1:0] v;
    v[0] = W'(a); v[1] = W'(b); v[2] = W'(c);
    v[3] = W'(d); v[4] = W'(e); v[5] = W'(f);
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      applied++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    logic [K-1:0][W-1:0] v;
    // R1: reset clears output even with nonzero operands present
    opnd = pack6(15, 15, 15, 15, 15, 15);
    opnd3 = {4'd15, 4'd15, 4'd15};
    @(negedge clk);
    @(negedge clk);
    check(int'(sum), 0, "R1");
    check(int'(sum3), 0, "R1");
    rst = 1'b0;

    apply('0, "R4");
    apply(pack6(15, 15, 15, 15, 15, 15), "R3");
    check(int'(sum), 90, "R3");
    apply(pack6(13, 10, 5, 11, 12, 1), "R6");
    check(int'(sum), 52, "R6");
    // R7: permutations of the same set
    apply(pack6(1, 12, 11, 5, 10, 13), "R7");
    check(int'(sum), 52, "R7");
    apply(pack6(5, 11, 13, 1, 10, 12), "R7");
    check(int'(sum), 52, "R7");
    apply(pack6(12, 1, 10, 13, 5, 11), "R7");
    check(int'(sum), 52, "R7");
    // R8: walking one full-scale operand through every slot
    for (int s = 0; s < K; s++) begin
      v = '0;
      v[s] = 4'd15;
      apply(v, "R8");
      check(int'(sum), 15, "R8");
      v[s] = 4'd9;
      apply(v, "R8");
      check(int'(sum), 9, "R8");
    end
    // R5: three-operand build
    opnd3[0] = 4'd9; opnd3[1] = 4'd12; opnd3[2] = 4'd13;
    @(negedge clk);
    check(int'(sum3), 34, "R5");
    // R2: random vectors, compared every clock
    for (int n = 0; n < 300; n++) begin
      for (int j = 0; j < K; j++) v[j] = W'($urandom);
      apply(v, "R2");
    end
    // R1: mid-run reset
    opnd = pack6(7, 7, 7, 7, 7, 7);
    rst = 1'b1;
    @(negedge clk);
    check(int'(sum), 0, "R1");
    rst = 1'b0;
    apply(pack6(7, 7, 7, 7, 7, 7), "R2");
    apply('0, "R4");
    check(int'(sum), 0, "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule